// File: doc/BRIEF.md
# Modular Multiplier Register Front-End

This block is the software-facing control layer of a modular-multiplication engine whose operands live in a shared, word-addressed RAM. It holds three configuration words and a modulus low-byte word. The three configuration words pair an operand pointer with a length or pass-count field. From the modulus low byte, the block derives the 8-bit Montgomery constant on its own. These values go out to the arithmetic datapath as steady registered outputs.

A write to the command word with any of its three operation bits set launches an operation. The block emits a one-cycle start pulse and holds the chosen operation as a one-hot code. It reports busy until the datapath answers with a one-cycle done pulse. That pulse also carries the overflow result, which the status word captures. At completion the command bits clear themselves. Reads go through a registered port with one cycle of latency.

Top module: `mmm_regbank`

Register map (word addresses on `bus_addr`):

| Address | Word | Contents |
|---|---|---|
| 0 | X config | pointer in [10:1], length in [25:16] |
| 1 | Y config | pointer in [10:1], pass count in [23:16] |
| 2 | N config | pointer in [10:1], length in [25:16] |
| 3 | Modulus low byte | modulus byte in [7:0], derived constant in [15:8] |
| 4 | Command | operation bits in [2:0] |
| 5 | Status | overflow in bit 0, busy in bit 1 |

## Requirements
- R1: After synchronous reset, every register reads zero, `mm_start` is low, `mm_op` is zero and all configuration outputs are zero.
- R2: The X, Y and N config words (addresses 0, 1, 2) store a pointer field from write-data bits [10:1]. Bit 0 and every unlisted bit read back as zero. The matching pointer output equals the field shifted left by one, so it is always even.
- R3: The X and N config words store a 10-bit length from bits [25:16]. The Y config word stores an 8-bit pass count from bits [23:16]. Each field reads back in place and drives its own output.
- R4: A write to address 3 stores bits [7:0] as the modulus byte. In the same edge it loads a constant C into read bits [15:8] and onto `nacc`, where C is chosen so that (byte × C) mod 256 = 255 for every odd byte. Write bits [15:8] and all bits above them are ignored.
- R5: A read strobe produces `bus_rvalid` high, with the addressed word on `bus_rdata`, exactly one cycle later. Addresses 6 and 7 read as zero.
- R6: Writing a non-zero value to the command word (address 4) while idle has four effects at the next edge: a single-cycle `mm_start`, busy set (status bit 1), overflow cleared (status bit 0), and the command word reading back the selected operation bit.
- R7: When several command bits are written together, the lowest-numbered set bit is the one selected. `mm_op` is one-hot while busy and zero while idle.
- R8: A command write while busy, and a command write of zero, are ignored: no start pulse, and the command and status words are unchanged.
- R9: A `mm_done` pulse while busy clears busy and the command word, and loads status bit 0 from `mm_ovf`.
- R10: A `mm_done` pulse while idle has no effect on status or on the command word.
- R11: When `mm_done` and a command write fall in the same cycle during a busy operation, the completion is taken and the command write is dropped.
- R12: Writes to the status word (address 5) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| mm_start | output | 1 | One-cycle launch pulse to the datapath |
| mm_op | output | 3 | One-hot selected operation, held while busy |
| mm_done | input | 1 | One-cycle completion pulse from the datapath |
| mm_ovf | input | 1 | Overflow result, valid with `mm_done` |
| x_base | output | 11 | X operand word pointer (even) |
| x_len | output | 10 | X length field (words minus one) |
| y_base | output | 11 | Y operand word pointer (even) |
| n_passes | output | 8 | Pass-count field (passes minus one) |
| n_base | output | 11 | N operand word pointer (even) |
| n_len | output | 10 | N length field (words minus one) |
| nacc | output | 8 | Derived Montgomery constant |

## Verification
Completion and a new launch request can meet in the same cycle. In that cycle a done pulse ends the running operation while software writes a fresh command. The bench drives both strobes between the same pair of edges. It then judges the outcome: no start pulse follows, the status shows idle with the overflow value carried by the done pulse, and the command word reads zero. A second overlap, a status read in the very cycle of completion, must return the pre-completion busy state. The read after it must show idle.

// File: rtl/mmm_regbank_pkg.sv
package mmm_regbank_pkg;
  // Word addresses of the register bank
  localparam int REG_XCFG   = 0;
  localparam int REG_YCFG   = 1;
  localparam int REG_NCFG   = 2;
  localparam int REG_MODLOW = 3;
  localparam int REG_CMD    = 4;
  localparam int REG_STAT   = 5;

  // Field positions inside the words
  localparam int PTR_LSB   = 1;
  localparam int HI_LSB    = 16;
  localparam int NACC_LSB  = 8;
  localparam int STAT_OVF  = 0;
  localparam int STAT_BUSY = 1;

  // One-hot operation codes seen on mm_op
  typedef enum logic [2:0] {
    OP_IDLE    = 3'b000,
    OP_MUL     = 3'b001,
    OP_MULNEXT = 3'b010,
    OP_EXP     = 3'b100
  } mm_op_e;
endpackage

// File: rtl/mmm_cfg_word.sv
module mmm_cfg_word #(
  parameter int DATA_W = 32,
  parameter int LO_LSB = 1,
  parameter int LO_W   = 10,
  parameter int HI_LSB = 16,
  parameter int HI_W   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [LO_W-1:0]   lo,
  output logic [HI_W-1:0]   hi,
  output logic [DATA_W-1:0] rd_word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lo <= '0;
      hi <= '0;
    end else if (wr) begin
      lo <= wdata[LO_LSB +: LO_W];
      hi <= wdata[HI_LSB +: HI_W];
    end
  end

  // Unlisted bits are zero on read
  always_comb begin
    rd_word = '0;
    rd_word[LO_LSB +: LO_W] = lo;
    rd_word[HI_LSB +: HI_W] = hi;
  end
endmodule

// File: rtl/mmm_nacc_calc.sv
module mmm_nacc_calc #(
  parameter int W = 8
) (
  input  logic [W-1:0] n_low,
  output logic [W-1:0] n_acc
);
  // Newton steps: each doubles the correct low bits, starting from 3
  localparam int ITERS = (W <= 3) ? 1 : $clog2(W);

  function automatic logic [W-1:0] neg_inverse(input logic [W-1:0] n);
    logic [W-1:0] inv;
    logic [W-1:0] two;
    two = W'(2);
    inv = n;
    for (int i = 0; i < ITERS; i++) begin
      inv = W'(inv * W'(two - W'(n * inv)));
    end
    return W'(-inv);
  endfunction

  assign n_acc = neg_inverse(n_low);
endmodule

// File: rtl/mmm_cmd_ctrl.sv
module mmm_cmd_ctrl #(
  parameter int CMD_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_wdata,
  input  logic             done,
  input  logic             done_ovf,
  output logic             start,
  output logic [CMD_W-1:0] op,
  output logic             busy,
  output logic             ovf
);
  logic [CMD_W-1:0] pick;

  // Isolate the lowest set bit: lowest-numbered command wins
  assign pick = cmd_wdata & CMD_W'(~cmd_wdata + CMD_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      start <= 1'b0;
      op    <= '0;
      busy  <= 1'b0;
      ovf   <= 1'b0;
    end else begin
      start <= 1'b0;
      if (busy && done) begin
        busy <= 1'b0;
        op   <= '0;
        ovf  <= done_ovf;
      end else if (!busy && cmd_wr && (|cmd_wdata)) begin
        busy  <= 1'b1;
        op    <= pick;
        ovf   <= 1'b0;
        start <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mmm_regbank.sv
module mmm_regbank
  import mmm_regbank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int PTR_W  = 10,
  parameter int LEN_W  = 10,
  parameter int PASS_W = 8,
  parameter int NZ_W   = 8,
  parameter int CMD_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              mm_start,
  output logic [CMD_W-1:0]  mm_op,
  input  logic              mm_done,
  input  logic              mm_ovf,
  output logic [PTR_W:0]    x_base,
  output logic [LEN_W-1:0]  x_len,
  output logic [PTR_W:0]    y_base,
  output logic [PASS_W-1:0] n_passes,
  output logic [PTR_W:0]    n_base,
  output logic [LEN_W-1:0]  n_len,
  output logic [NZ_W-1:0]   nacc
);
  localparam int NUM_CFG = 3;

  logic [DATA_W-1:0] cfg_rd [NUM_CFG];
  logic [PTR_W-1:0]  x_ptr, y_ptr, n_ptr;
  logic              sel_cmd, sel_mod;
  logic [NZ_W-1:0]   nzero_q, nacc_q, nacc_new;
  logic              busy_w, ovf_w;
  logic [DATA_W-1:0] rd_mux;

  assign sel_mod = bus_wr && (bus_addr == ADDR_W'(REG_MODLOW));
  assign sel_cmd = bus_wr && (bus_addr == ADDR_W'(REG_CMD));

  mmm_cfg_word #(.DATA_W(DATA_W), .LO_LSB(PTR_LSB), .LO_W(PTR_W),
                 .HI_LSB(HI_LSB), .HI_W(LEN_W)) u_xcfg (
    .clk(clk), .rst(rst), .wr(bus_wr && (bus_addr == ADDR_W'(REG_XCFG))),
    .wdata(bus_wdata), .lo(x_ptr), .hi(x_len), .rd_word(cfg_rd[0]));

  mmm_cfg_word #(.DATA_W(DATA_W), .LO_LSB(PTR_LSB), .LO_W(PTR_W),
                 .HI_LSB(HI_LSB), .HI_W(PASS_W)) u_ycfg (
    .clk(clk), .rst(rst), .wr(bus_wr && (bus_addr == ADDR_W'(REG_YCFG))),
    .wdata(bus_wdata), .lo(y_ptr), .hi(n_passes), .rd_word(cfg_rd[1]));

  mmm_cfg_word #(.DATA_W(DATA_W), .LO_LSB(PTR_LSB), .LO_W(PTR_W),
                 .HI_LSB(HI_LSB), .HI_W(LEN_W)) u_ncfg (
    .clk(clk), .rst(rst), .wr(bus_wr && (bus_addr == ADDR_W'(REG_NCFG))),
    .wdata(bus_wdata), .lo(n_ptr), .hi(n_len), .rd_word(cfg_rd[2]));

  // Pointers are word addresses with an implied zero LSB
  assign x_base = {x_ptr, 1'b0};
  assign y_base = {y_ptr, 1'b0};
  assign n_base = {n_ptr, 1'b0};

  // Montgomery constant derived in the same cycle as the byte write
  mmm_nacc_calc #(.W(NZ_W)) u_nacc (
    .n_low(bus_wdata[NZ_W-1:0]), .n_acc(nacc_new));

  always_ff @(posedge clk) begin
    if (rst) begin
      nzero_q <= '0;
      nacc_q  <= '0;
    end else if (sel_mod) begin
      nzero_q <= bus_wdata[NZ_W-1:0];
      nacc_q  <= nacc_new;
    end
  end
  assign nacc = nacc_q;

  mmm_cmd_ctrl #(.CMD_W(CMD_W)) u_ctrl (
    .clk(clk), .rst(rst), .cmd_wr(sel_cmd), .cmd_wdata(bus_wdata[CMD_W-1:0]),
    .done(mm_done), .done_ovf(mm_ovf), .start(mm_start), .op(mm_op),
    .busy(busy_w), .ovf(ovf_w));

  always_comb begin
    rd_mux = '0;
    case (int'(bus_addr))
      REG_XCFG:   rd_mux = cfg_rd[0];
      REG_YCFG:   rd_mux = cfg_rd[1];
      REG_NCFG:   rd_mux = cfg_rd[2];
      REG_MODLOW: begin
        rd_mux[NZ_W-1:0]          = nzero_q;
        rd_mux[NACC_LSB +: NZ_W]  = nacc_q;
      end
      REG_CMD:    rd_mux[CMD_W-1:0] = mm_op;
      REG_STAT: begin
        rd_mux[STAT_OVF]  = ovf_w;
        rd_mux[STAT_BUSY] = busy_w;
      end
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/mmm_regbank_chk.sv
module mmm_regbank_chk #(
  parameter int CMD_W = 3,
  parameter int NZ_W  = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_rd,
  input logic             bus_rvalid,
  input logic             mm_start,
  input logic [CMD_W-1:0] mm_op,
  input logic             mm_done,
  input logic             mm_ovf,
  input logic             busy,
  input logic             ovf,
  input logic [NZ_W-1:0]  nzero,
  input logic [NZ_W-1:0]  nacc
);
  logic [NZ_W-1:0] prod_low;
  assign prod_low = NZ_W'(nzero * nacc);

  p_rvalid_lat_r5: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  p_start_single_r6: assert property (@(posedge clk) disable iff (rst)
    mm_start |=> !mm_start);

  p_start_on_launch_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (mm_start && !ovf));

  p_no_start_busy_r8: assert property (@(posedge clk) disable iff (rst)
    mm_start |-> $rose(busy));

  p_op_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> ($countones(mm_op) == 1));

  p_op_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (mm_op == '0));

  p_done_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && mm_done) |=> (!busy && (ovf == $past(mm_ovf))));

  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && mm_done) |=> $stable(ovf));

  p_nacc_rel_r4: assert property (@(posedge clk) disable iff (rst)
    nzero[0] |-> (prod_low == '1));
endmodule

bind mmm_regbank mmm_regbank_chk #(.CMD_W(CMD_W), .NZ_W(NZ_W)) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_rvalid(bus_rvalid),
  .mm_start(mm_start), .mm_op(mm_op), .mm_done(mm_done), .mm_ovf(mm_ovf),
  .busy(busy_w), .ovf(ovf_w), .nzero(nzero_q), .nacc(nacc_q));

// File: tb/mmm_regbank_tb.sv
module mmm_regbank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, mm_start, mm_done = 1'b0, mm_ovf = 1'b0;
  logic [2:0]  mm_op;
  logic [10:0] x_base, y_base, n_base;
  logic [9:0]  x_len, n_len;
  logic [7:0]  n_passes, nacc;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mmm_regbank u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .mm_start(mm_start), .mm_op(mm_op), .mm_done(mm_done), .mm_ovf(mm_ovf),
    .x_base(x_base), .x_len(x_len), .y_base(y_base), .n_passes(n_passes),
    .n_base(n_base), .n_len(n_len), .nacc(nacc));

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    check(bus_rvalid === 1'b1, "R5 rvalid", {31'b0, bus_rvalid}, 32'h1);
    d = bus_rdata;
  endtask

  task automatic done_pulse(input logic o);
    mm_done = 1'b1; mm_ovf = o;
    @(negedge clk);
    mm_done = 1'b0; mm_ovf = 1'b0;
  endtask

  function automatic logic [2:0] lowest(input logic [2:0] c);
    for (int i = 0; i < 3; i++) if (c[i]) return 3'(1 << i);
    return 3'b000;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual %h expected %h", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    logic [31:0] d, pats [6];
    logic [7:0]  kexp;
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000; pats[2] = 32'hA5A5_5A5A;
    pats[3] = 32'h5A5A_A5A5; pats[4] = 32'h0155_0003; pats[5] = 32'h02AA_0554;

    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check(d == 0, "R1 reset read", d, 0);
    end
    check(mm_start == 0 && mm_op == 0 && nacc == 0 && x_base == 0 && n_len == 0,
          "R1 outputs", {mm_start, mm_op, nacc, x_base[7:0], n_len[7:0]}, 0);

    // R2, R3 field sweep on each config word
    for (int p = 0; p < 6; p++) begin
      wr(3'd0, pats[p]); wr(3'd1, ~pats[p]); wr(3'd2, pats[p] ^ 32'h0F0F_0F0F);
      rd(3'd0, d);
      check(d == (pats[p] & 32'h03FF_07FE), "R2 R3 X readback", d, pats[p] & 32'h03FF_07FE);
      rd(3'd1, d);
      check(d == (~pats[p] & 32'h00FF_07FE), "R2 R3 Y readback", d, ~pats[p] & 32'h00FF_07FE);
      rd(3'd2, d);
      check(d == ((pats[p] ^ 32'h0F0F_0F0F) & 32'h03FF_07FE), "R2 R3 N readback",
            d, (pats[p] ^ 32'h0F0F_0F0F) & 32'h03FF_07FE);
      check(x_base == {pats[p][10:1], 1'b0}, "R2 x_base", 32'(x_base), 32'({pats[p][10:1], 1'b0}));
      check(y_base == {~pats[p][10:1], 1'b0}, "R2 y_base", 32'(y_base), 32'({~pats[p][10:1], 1'b0}));
      check(x_len == pats[p][25:16], "R3 x_len", 32'(x_len), 32'(pats[p][25:16]));
      check(n_passes == ~pats[p][23:16], "R3 n_passes", 32'(n_passes), 32'(~pats[p][23:16]));
      check(n_len == (pats[p][25:16] ^ 10'h30F), "R3 n_len", 32'(n_len), 32'(pats[p][25:16] ^ 10'h30F));
      check(n_base == {pats[p][10:1] ^ 10'h387, 1'b0}, "R2 n_base", 32'(n_base),
            32'({pats[p][10:1] ^ 10'h387, 1'b0}));
    end

    // R4 exhaustive over the modulus byte
    for (int v = 0; v < 256; v++) begin
      wr(3'd3, 32'hFFFF_5A00 | 32'(v));
      rd(3'd3, d);
      check(d[7:0] == 8'(v) && d[31:16] == 0, "R4 byte readback", d, 32'(v));
      if (v % 2 == 1) begin
        kexp = 0;
        for (int k = 0; k < 256; k++) if (((v * k) & 255) == 255) kexp = 8'(k);
        check(d[15:8] == kexp, "R4 constant read", 32'(d[15:8]), 32'(kexp));
        check(nacc == kexp, "R4 constant port", 32'(nacc), 32'(kexp));
      end
    end

    // R5 unmapped and no-read cases
    wr(3'd6, 32'hFFFF_FFFF); wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd6, d); check(d == 0, "R5 addr6", d, 0);
    rd(3'd7, d); check(d == 0, "R5 addr7", d, 0);
    @(negedge clk);
    check(bus_rvalid == 0, "R5 rvalid idle", 32'(bus_rvalid), 0);

    // R6 R7 R8 R9 every command code
    done_pulse(1'b0);
    for (int c = 1; c < 8; c++) begin
      wr(3'd4, 32'hFFFF_FFF8 | 32'(c));
      check(mm_start == 1, "R6 start", 32'(mm_start), 1);
      check(mm_op == lowest(3'(c)), "R7 op", 32'(mm_op), 32'(lowest(3'(c))));
      rd(3'd5, d);
      check(mm_start == 0 || 1'b0, "R6 start single", 32'(mm_start), 0);
      check(d == 32'h2, "R6 status launch", d, 2);
      rd(3'd4, d);
      check(d == 32'(lowest(3'(c))), "R7 cmd readback", d, 32'(lowest(3'(c))));
      wr(3'd4, 32'h7);
      check(mm_start == 0, "R8 busy write no start", 32'(mm_start), 0);
      wr(3'd4, 32'h0);
      rd(3'd4, d);
      check(d == 32'(lowest(3'(c))), "R8 cmd kept", d, 32'(lowest(3'(c))));
      done_pulse(c[0]);
      rd(3'd5, d);
      check(d == 32'(c[0]), "R9 status done", d, 32'(c[0]));
      rd(3'd4, d);
      check(d == 0 && mm_op == 0, "R9 cmd cleared", d, 0);
      wr(3'd4, 32'h0);
      check(mm_start == 0, "R8 zero write", 32'(mm_start), 0);
    end

    // R10 done while idle (overflow currently 1)
    done_pulse(1'b0);
    rd(3'd5, d);
    check(d == 32'h1, "R10 idle done", d, 1);

    // R12 status write ignored
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, d);
    check(d == 32'h1, "R12 status write", d, 1);

    // R11 done and command write in the same cycle
    wr(3'd4, 32'h2);
    rd(3'd5, d);
    check(d == 32'h2, "R6 overflow cleared", d, 2);
    mm_done = 1'b1; mm_ovf = 1'b1; bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 32'h4;
    @(negedge clk);
    mm_done = 1'b0; mm_ovf = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    check(mm_start == 0 && mm_op == 0, "R11 no relaunch", {mm_start, mm_op}, 0);
    rd(3'd5, d);
    check(d == 32'h1, "R11 status", d, 1);
    rd(3'd4, d);
    check(d == 0, "R11 cmd", d, 0);

    // R9 read in completion cycle sees pre-completion state
    wr(3'd4, 32'h1);
    mm_done = 1'b1; bus_rd = 1'b1; bus_addr = 3'd5;
    @(negedge clk);
    mm_done = 1'b0; bus_rd = 1'b0;
    check(bus_rdata == 32'h2, "R9 read at done", bus_rdata, 2);
    rd(3'd5, d);
    check(d == 32'h0, "R9 read after done", d, 0);

    finish_run();
  end
endmodule